// File: doc/BRIEF.md
# Serial NOR Flash Command Slave

This block is a slave on a four-wire SPI bus (active-low select, serial clock, data in, data out). It behaves like a small serial NOR flash whose storage is a register array of a few 256-byte pages. The host can arm writes, program a page, and stream data back. The SPI pins are synchronised into the system clock domain. SCK edges are found by oversampling. The bus runs in mode 0: MOSI is captured on the rising SCK edge, and MISO changes after the falling edge.

Three command codes are decoded. Code 0x06 arms the write latch. Code 0x0A is a page program, and it runs only when the write latch is armed. Code 0x0B is a fast read: a 24-bit address, one dummy byte, and then data for as long as select stays low.

A page program first copies the addressed page into a page buffer and updates the buffer byte by byte. The whole buffer goes back to the array only when select rises. Bytes that the host did not send therefore keep their old values.

The control FSM has these states:

- CMD_PH: collects the command byte. It goes to ADDR_PH on 0x0B, or on 0x0A with the latch armed. It goes to SKIP_PH on 0x06, on 0x0A without the latch, or on any other code.
- ADDR_PH: collects three address bytes, most significant first. It then goes to WDATA_PH for a program, or to DUMMY_PH for a read.
- DUMMY_PH: discards one byte and then goes to RDATA_PH.
- RDATA_PH: shifts out array bytes.
- WDATA_PH: fills the page buffer.
- SKIP_PH: ignores the rest of the frame.

Select going high returns every state to CMD_PH.

Top module: `spif_flash_slave`

## Requirements
- R1: After reset the write latch is clear, every array byte reads 0x00, and spi_miso_oe is 0.
- R2: A page program (code 0x0A) changes the array only if a write-enable frame (code 0x06, sent as its own 8-bit frame) completed earlier. Without one, the array is unchanged.
- R3: A page program frame is code 0x0A, then a 24-bit address sent MSB first, then data bytes sent MSB first. The first data byte goes to the addressed byte and the following bytes go to successive offsets.
- R4: When a data byte's offset passes 255, it wraps to offset 0 of the same page. The page bits of the address stay fixed, and a later byte overwrites an earlier one.
- R5: In a committed page program, page bytes that received no data keep their previous contents.
- R6: A page program takes effect when select rises, and only if select rises on a byte boundary with at least one data byte received. A frame that ends mid-byte, or has no data byte, leaves the array and the write latch unchanged.
- R7: A committed page program clears the write latch. A second program without a new write-enable is ignored.
- R8: A fast read (code 0x0B) is the code, a 24-bit address and one dummy byte. After these, array bytes are driven MSB first on MISO until select rises. Each bit is driven after the falling SCK edge and is valid at the next rising edge.
- R9: During a fast read the address increments after every byte and wraps from the last array byte to byte 0. Address bits above the array size (including bits 23 to 20) are ignored.
- R10: spi_miso_oe is 1 only during the data phase of a fast read, from its first falling edge until select rises. Otherwise spi_miso is high impedance.
- R11: An unknown command code makes the rest of the frame ignored until select rises. A 0x06 byte later in the same frame does not arm the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave; high impedance when not driven |
| spi_miso_oe | output | 1 | High while spi_miso is driven |

## Verification
The case that is hardest to reach from the pins is a program frame cut short. The latch is armed and a data byte has been fully received, but select rises part way through the next byte. The buffer already holds new data at that point, so the commit decision depends only on the bit count. The bench has a task that sends a chosen number of bits of a partial byte before raising select. It then reads the page back and issues a second program with no new write-enable, which proves that the latch survived the aborted frame. Random frames with random 24-bit addresses, lengths and high address bits are mixed in, so that page wrap and array-top wrap occur many times.

// File: rtl/spif_pkg.sv
package spif_pkg;
    typedef enum logic [2:0] {
        CMD_PH,
        ADDR_PH,
        DUMMY_PH,
        RDATA_PH,
        WDATA_PH,
        SKIP_PH
    } spif_state_e;

    localparam logic [7:0] OP_ARM   = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h0A;
    localparam logic [7:0] OP_FREAD = 8'h0B;
endpackage

// File: rtl/spif_pin_sync.sv
module spif_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic [STAGES-1:0] cs_q, sck_q, mosi_q;
    logic              sck_d, cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
            sck_q  <= {sck_q[STAGES-2:0], sck_i};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
            sck_d  <= sck_q[STAGES-1];
            cs_d   <= cs_q[STAGES-1];
        end
    end

    assign cs_n_o   = cs_q[STAGES-1];
    assign mosi_o   = mosi_q[STAGES-1];
    assign sck_rise = sck_q[STAGES-1] & ~sck_d & ~cs_q[STAGES-1];
    assign sck_fall = ~sck_q[STAGES-1] & sck_d & ~cs_q[STAGES-1];
    assign cs_rise  = cs_q[STAGES-1] & ~cs_d;
endmodule

// File: rtl/spif_page_store.sv
module spif_page_store #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 256
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          load,
    input  logic [$clog2(PAGES)-1:0]                      load_page,
    input  logic                                          wr,
    input  logic [$clog2(PAGE_BYTES)-1:0]                 wr_off,
    input  logic [7:0]                                    wr_data,
    input  logic                                          commit,
    input  logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0]   rd_addr,
    output logic [7:0]                                    rd_data
);
    localparam int OW        = $clog2(PAGE_BYTES);
    localparam int PW        = $clog2(PAGES);
    localparam int MEM_BYTES = PAGES * PAGE_BYTES;

    logic [7:0]    mem  [MEM_BYTES];
    logic [7:0]    pbuf [PAGE_BYTES];
    logic [PW-1:0] pg_q;
    logic          buf_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
            pg_q     <= '0;
            buf_live <= 1'b0;
        end else begin
            if (load) begin
                pg_q     <= load_page;
                buf_live <= 1'b1;
                for (int i = 0; i < PAGE_BYTES; i++)
                    pbuf[i] <= mem[{load_page, i[OW-1:0]}];
            end else if (wr) begin
                pbuf[wr_off] <= wr_data;
            end
            if (commit) begin
                buf_live <= 1'b0;
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem[{pg_q, i[OW-1:0]}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R3
    commit_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> buf_live);
    // R3
    load_commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && commit));
endmodule

// File: rtl/spif_flash_slave.sv
module spif_flash_slave
    import spif_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int PAGE_BYTES  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int PW = $clog2(PAGES);
    localparam int AW = OW + PW;

    logic        cs_n_s, mosi_s, sck_rise, sck_fall, cs_rise;
    spif_state_e state, nstate;
    logic [2:0]  bit_cnt, tx_cnt;
    logic [1:0]  byte_cnt;
    logic [6:0]  rx_sr;
    logic [7:0]  rx_byte, tx_sr, rd_data;
    logic [23:0] addr, addr_nx;
    logic [OW-1:0] wr_off;
    logic        is_wr, wel, wr_any, oe_q, miso_q;
    logic        byte_done, st_load, st_wr, ld_tx, commit;

    spif_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
        .cs_n_o(cs_n_s), .mosi_o(mosi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spif_page_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) i_store (
        .clk(clk), .rst_n(rst_n),
        .load(st_load), .load_page(addr_nx[AW-1:OW]),
        .wr(st_wr), .wr_off(wr_off), .wr_data(rx_byte),
        .commit(commit), .rd_addr(addr[AW-1:0]), .rd_data(rd_data)
    );

    assign rx_byte   = {rx_sr, mosi_s};
    assign addr_nx   = {addr[15:0], rx_byte};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign commit    = cs_rise && (state == WDATA_PH) && (bit_cnt == 3'd0) && wr_any;

    always_comb begin
        nstate  = state;
        st_load = 1'b0;
        st_wr   = 1'b0;
        ld_tx   = 1'b0;
        if (cs_n_s) begin
            nstate = CMD_PH;
        end else if (byte_done) begin
            unique case (state)
                CMD_PH: begin
                    if (rx_byte == OP_FREAD || (rx_byte == OP_PROG && wel))
                        nstate = ADDR_PH;
                    else
                        nstate = SKIP_PH;
                end
                ADDR_PH: begin
                    if (byte_cnt == 2'd2) begin
                        nstate  = is_wr ? WDATA_PH : DUMMY_PH;
                        st_load = is_wr;
                    end
                end
                DUMMY_PH: begin
                    nstate = RDATA_PH;
                    ld_tx  = 1'b1;
                end
                WDATA_PH: st_wr = 1'b1;
                RDATA_PH, SKIP_PH: nstate = state;
                default: nstate = CMD_PH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_PH;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            tx_cnt   <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            addr     <= '0;
            wr_off   <= '0;
            is_wr    <= 1'b0;
            wel      <= 1'b0;
            wr_any   <= 1'b0;
            oe_q     <= 1'b0;
            miso_q   <= 1'b0;
        end else if (cs_n_s) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            tx_cnt   <= '0;
            wr_any   <= 1'b0;
            oe_q     <= 1'b0;
            if (commit) wel <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sr   <= {rx_sr[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                case (state)
                    CMD_PH: begin
                        is_wr <= (rx_byte == OP_PROG);
                        if (rx_byte == OP_ARM) wel <= 1'b1;
                    end
                    ADDR_PH: begin
                        addr     <= addr_nx;
                        byte_cnt <= byte_cnt + 2'd1;
                        if (byte_cnt == 2'd2) wr_off <= addr_nx[OW-1:0];
                    end
                    WDATA_PH: begin
                        wr_off <= wr_off + 1'b1;
                        wr_any <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (ld_tx) begin
                tx_sr          <= rd_data;
                addr[AW-1:0]   <= addr[AW-1:0] + 1'b1;
                tx_cnt         <= '0;
            end
            if (sck_fall && state == RDATA_PH) begin
                miso_q <= tx_sr[7];
                oe_q   <= 1'b1;
                tx_cnt <= tx_cnt + 3'd1;
                if (tx_cnt == 3'd7) begin
                    tx_sr        <= rd_data;
                    addr[AW-1:0] <= addr[AW-1:0] + 1'b1;
                end else begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso_oe = oe_q;
    assign spi_miso    = oe_q ? miso_q : 1'bz;

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel);
    // R2
    write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WDATA_PH) |-> wel);
    // R10
    oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state == RDATA_PH));
    // R8
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> ($past(state) == RDATA_PH));
endmodule

// File: tb/test_spif_flash_slave.sv
`timescale 1ns/1ps
module test_spif_flash_slave;
    localparam int PAGES = 4;
    localparam int PB    = 256;
    localparam int MEM   = PAGES * PB;
    localparam int HP    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    wire  miso;
    wire  miso_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MEM];
    bit wel_m = 1'b0;

    always #2.5 clk = ~clk;

    spif_flash_slave #(.PAGES(PAGES), .PAGE_BYTES(PB)) i_spif_flash_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    function automatic int mem_idx(input logic [23:0] a);
        return int'(a) % MEM;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
        oe_seen = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HP) @(negedge clk);
            rx[b] = miso;
            oe_seen = oe_seen | miso_oe;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic put(input logic [7:0] tx);
        logic [7:0] r;
        logic o;
        xfer(tx, r, o);
    endtask

    task automatic begin_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic end_frame();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HP) @(negedge clk);
    endtask

    task automatic do_arm();
        begin_frame(); put(8'h06); end_frame();
        wel_m = 1'b1;
    endtask

    // partial_bits > 0: append that many bits of an extra byte before select rises
    task automatic do_prog(input logic [23:0] a, input int n, input int partial_bits);
        logic [7:0] d [];
        int base, off;
        d = new[n];
        begin_frame();
        put(8'h0A); put(a[23:16]); put(a[15:8]); put(a[7:0]);
        for (int k = 0; k < n; k++) begin
            d[k] = 8'($urandom);
            put(d[k]);
        end
        for (int b = 0; b < partial_bits; b++) begin
            mosi = b[0];
            repeat (HP) @(negedge clk);
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        end_frame();
        if (wel_m && n > 0 && partial_bits == 0) begin
            base = (mem_idx(a) / PB) * PB;
            off  = int'(a[7:0]);
            for (int k = 0; k < n; k++) model[base + ((off + k) % PB)] = d[k];
            wel_m = 1'b0;
        end
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input string req);
        logic [7:0] r;
        logic o, o_any;
        o_any = 1'b0;
        begin_frame();
        xfer(8'h0B, r, o); o_any |= o;
        xfer(a[23:16], r, o); o_any |= o;
        xfer(a[15:8], r, o); o_any |= o;
        xfer(a[7:0], r, o); o_any |= o;
        xfer(8'hFF, r, o); o_any |= o;
        check({"R10 oe low before data (", req, ")"}, {31'd0, o_any}, 32'd0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, o);
            check(req, {24'd0, r}, {24'd0, model[(mem_idx(a) + k) % MEM]});
        end
        end_frame();
        check("R10 oe low after frame", {31'd0, miso_oe}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got hang exp finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 oe after reset", {31'd0, miso_oe}, 32'd0);
        check("R1 miso tristate", {31'd0, miso === 1'bz}, 32'd1);
        do_read(24'h000000, 8, "R1 array zero");

        // R2: program without arming is ignored
        do_prog(24'h000110, 4, 0);
        do_read(24'h000110, 4, "R2 unarmed program ignored");

        // R3 R4 R5: armed program with wrap inside page 1
        do_arm();
        do_prog(24'h0001F0, 20, 0);
        do_read(24'h000100, PB, "R3 R4 R5 page after wrap");

        // R7: latch cleared after commit
        do_prog(24'h000120, 3, 0);
        do_read(24'h000120, 3, "R7 second program ignored");

        // R11: unknown code then arm byte in same frame
        begin_frame(); put(8'h55); put(8'h06); end_frame();
        do_prog(24'h000200, 3, 0);
        do_read(24'h000200, 3, "R11 unknown frame did not arm");

        // R6: aborted mid-byte, then no data bytes, latch survives
        do_arm();
        do_prog(24'h000300, 2, 5);
        do_read(24'h000300, 2, "R6 mid-byte abort discarded");
        do_prog(24'h000310, 0, 0);
        do_prog(24'h000320, 2, 0);
        do_read(24'h000310, 20, "R6 latch kept, later program committed");

        // R9: wrap at array top with high address bits set
        do_arm();
        do_prog(24'hF003FE, 4, 0);
        do_read(24'hF803FD, 6, "R9 read wraps top to zero");
        do_read(24'hA00001, 3, "R8 R9 read with high bits");

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [23:0] a;
            int op;
            a  = 24'($urandom);
            op = int'($urandom_range(0, 3));
            if (op == 0) do_arm();
            else if (op == 1) begin
                do_arm();
                do_prog(a, int'($urandom_range(1, 24)), 0);
            end else if (op == 2) do_prog(a, int'($urandom_range(1, 6)), 0);
            else do_read(a, int'($urandom_range(1, 16)), "R8 random read");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule